// File: doc/BRIEF.md
# Address Bit-20 Wraparound Mask Unit

This unit sits on the physical address path of a processor core, between address generation and both the internal cache lookup and the external bus cycle logic. When an asynchronous, active-low mask request is held, the unit forces address bit 20 to zero so that real-mode addresses wrap at the 1 MiB boundary. The request is synchronized and delayed so that it takes effect exactly four clocks after it is asserted. The same delay applies when the request is released.

The unit follows bus activity so that the mask never changes in the middle of a transfer. A cycle starts with the address strobe, and the mask decision in force at that strobe is latched. The decision is held until the cycle ends: on ready for data, I/O and invalidation cycles, and on ready together with a last-transfer flag for a prefetch. A prefetch keeps its decision across all of its partial transfers. The completion of an I/O write shortens the request delay to the synchronizer depth, so that the instruction after the write sees the new mask state. The mask is never applied to cache invalidation cycles or outside real mode.

The unit checks the request at the first clock after reset is released. If the request is already active at that clock, the unit raises a sticky violation flag and ignores the request until it has been released once.

Top module: `a20_wrap_unit`

## Requirements
- R1: While reset is asserted and after it is released with the request inactive, `addr_out` equals `addr_in` and `reset_viol` is 0.
- R2: With the unit idle, in real mode and on a data cycle kind, bit 20 of `addr_out` is cleared starting on the 4th rising clock edge after `mask_req_n` goes low, and not sooner.
- R3: After `mask_req_n` returns high, bit 20 of `addr_out` follows `addr_in` again starting on the 4th rising edge, and not sooner.
- R4: For cycle kind 2'b11 (cache invalidation), whether the kind is presented while idle or latched at a strobe, `addr_out` equals `addr_in`.
- R5: With `real_mode` low, `addr_out` equals `addr_in` regardless of the request.
- R6: A cycle of kind 2'b00 (data) keeps the mask decision that was in force at its strobe until `rdy`, in both directions. The next cycle uses the current decision.
- R7: A cycle of kind 2'b01 (prefetch) keeps the decision from its first strobe through later strobes and through `rdy` cycles with `last_xfer` low. It ends only on `rdy` with `last_xfer` high.
- R8: When a cycle of kind 2'b10 (I/O write) ends on `rdy`, the synchronized request is loaded into the delay stages. A request made 2 clocks before that `rdy` is therefore in effect right after it.
- R9: If `mask_req_n` is low at the first clock after reset is released, `reset_viol` is set and stays set. The request is ignored until it has been released once, and after that it works normally.
- R10: All bits of `addr_out` other than bit 20 always equal those of `addr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| mask_req_n | input | 1 | Asynchronous bit-20 mask request, active low |
| real_mode | input | 1 | High when the core is in real mode |
| cyc_kind | input | 2 | Cycle kind: 00 data, 01 prefetch, 10 I/O write, 11 invalidation |
| strobe | input | 1 | Address strobe, starts a cycle |
| rdy | input | 1 | Transfer ready |
| last_xfer | input | 1 | Last transfer of a prefetch, qualifies `rdy` |
| addr_in | input | ADDR_W | Raw physical address |
| addr_out | output | ADDR_W | Address after the bit-20 mask |
| reset_viol | output | 1 | Sticky flag: request active at reset release |

## Verification
The request takes effect on the fourth rising edge after it is asserted, and is released on the fourth edge after it is removed. The bench changes its inputs just after a falling edge and samples 1 ns later. This places the first masked sample on the fourth falling edge after the request, and the bench also checks the third edge, which must still be unmasked. A latched cycle decision is visible at `addr_out` at the edge that starts the cycle, and the next cycle takes the new decision right after the closing `rdy` edge. The I/O write fast path is checked at the sample straight after its `rdy` edge, which is three edges after the request and one edge before the normal path would mask. The reset violation flag is checked one edge after reset is released.

// File: rtl/a20m_pkg.sv
package a20m_pkg;

    typedef enum logic [1:0] {
        KIND_DATA     = 2'b00,
        KIND_PREFETCH = 2'b01,
        KIND_IOWR     = 2'b10,
        KIND_INVAL    = 2'b11
    } cyc_kind_e;

    typedef struct packed {
        logic      busy;
        cyc_kind_e kind;
        logic      dec;
    } track_st_t;

endpackage

// File: rtl/a20m_req_pipe.sv
module a20m_req_pipe #(
    parameter int LATENCY     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mask_req_n,
    input  logic io_done,
    output logic eff_mask,
    output logic pre_stage,
    output logic stage_first,
    output logic ignoring,
    output logic reset_viol
);
    localparam int DELAY_STAGES = LATENCY - SYNC_STAGES;

    typedef struct packed {
        logic [LATENCY-1:0] pipe;
        logic               ign;
        logic               viol;
        logic               seen;
    } pipe_st_t;

    pipe_st_t st_d, st_q;
    logic req_on, first_clk, catch_bad, gated;

    always_comb begin
        st_d      = st_q;
        req_on    = !mask_req_n;
        first_clk = !st_q.seen;
        catch_bad = first_clk & req_on;
        gated     = req_on & !st_q.ign & !catch_bad;
        st_d.seen = 1'b1;
        st_d.viol = st_q.viol | catch_bad;
        st_d.ign  = (st_q.ign | catch_bad) & req_on;
        st_d.pipe = {st_q.pipe[LATENCY-2:0], gated};
        if (io_done && DELAY_STAGES > 0) begin
            for (int i = SYNC_STAGES; i < LATENCY; i++) begin
                st_d.pipe[i] = st_q.pipe[SYNC_STAGES-1];
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_mask    = st_q.pipe[LATENCY-1];
    assign pre_stage   = st_q.pipe[LATENCY-2];
    assign stage_first = st_q.pipe[0];
    assign ignoring    = st_q.ign;
    assign reset_viol  = st_q.viol;
endmodule

// File: rtl/a20m_cycle_track.sv
module a20m_cycle_track
    import a20m_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  logic      rdy,
    input  logic      last_xfer,
    input  cyc_kind_e kind_in,
    input  logic      eff_mask,
    output cyc_kind_e cur_kind,
    output logic      use_mask,
    output logic      io_done,
    output logic      busy,
    output logic      held
);
    track_st_t st_d, st_q;
    logic start, active, finish;

    always_comb begin
        st_d     = st_q;
        start    = strobe & !st_q.busy;
        active   = start | st_q.busy;
        cur_kind = st_q.busy ? st_q.kind : kind_in;
        finish   = active & rdy & ((cur_kind != KIND_PREFETCH) | last_xfer);
        io_done  = finish & (cur_kind == KIND_IOWR);
        st_d.busy = active & !finish;
        if (start) begin
            st_d.kind = kind_in;
            st_d.dec  = eff_mask;
        end
        use_mask = st_q.busy ? st_q.dec : eff_mask;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '{busy: 1'b0, kind: KIND_DATA, dec: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign held = st_q.dec;
endmodule

// File: rtl/a20m_addr_gate.sv
module a20m_addr_gate
    import a20m_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MASK_BIT = 20
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              real_mode,
    input  cyc_kind_e         cur_kind,
    input  logic              use_mask,
    output logic [ADDR_W-1:0] addr_out
);
    localparam logic [ADDR_W-1:0] BIT_SEL = ADDR_W'(1) << MASK_BIT;

    logic mask_on;

    always_comb begin
        mask_on  = real_mode & use_mask & (cur_kind != KIND_INVAL);
        addr_out = mask_on ? (addr_in & ~BIT_SEL) : addr_in;
    end
endmodule

// File: rtl/a20_wrap_unit.sv
module a20_wrap_unit
    import a20m_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int MASK_BIT    = 20,
    parameter int LATENCY     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_req_n,
    input  logic              real_mode,
    input  logic [1:0]        cyc_kind,
    input  logic              strobe,
    input  logic              rdy,
    input  logic              last_xfer,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              reset_viol
);
    logic      eff_mask, pre_stage, stage_first, ignoring;
    logic      io_done, use_mask, busy, held;
    cyc_kind_e kind_in, cur_kind;

    assign kind_in = cyc_kind_e'(cyc_kind);

    a20m_req_pipe #(
        .LATENCY    (LATENCY),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_req_pipe (
        .clk        (clk),
        .rst        (rst),
        .mask_req_n (mask_req_n),
        .io_done    (io_done),
        .eff_mask   (eff_mask),
        .pre_stage  (pre_stage),
        .stage_first(stage_first),
        .ignoring   (ignoring),
        .reset_viol (reset_viol)
    );

    a20m_cycle_track u_track (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .rdy      (rdy),
        .last_xfer(last_xfer),
        .kind_in  (kind_in),
        .eff_mask (eff_mask),
        .cur_kind (cur_kind),
        .use_mask (use_mask),
        .io_done  (io_done),
        .busy     (busy),
        .held     (held)
    );

    a20m_addr_gate #(
        .ADDR_W  (ADDR_W),
        .MASK_BIT(MASK_BIT)
    ) u_gate (
        .addr_in  (addr_in),
        .real_mode(real_mode),
        .cur_kind (cur_kind),
        .use_mask (use_mask),
        .addr_out (addr_out)
    );
endmodule

// File: rtl/a20m_chk.sv
module a20m_chk #(
    parameter int ADDR_W   = 32,
    parameter int MASK_BIT = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              real_mode,
    input logic [1:0]        cyc_kind,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              eff_mask,
    input logic              pre_stage,
    input logic              stage_first,
    input logic              ignoring,
    input logic              io_done,
    input logic              busy,
    input logic              held,
    input logic              reset_viol
);
    localparam logic [ADDR_W-1:0] BIT_SEL = ADDR_W'(1) << MASK_BIT;

    // R10
    other_bits_chk: assert property (@(posedge clk) disable iff (rst)
        ((addr_out | BIT_SEL) == (addr_in | BIT_SEL)));

    // R5
    prot_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !real_mode |-> (addr_out == addr_in));

    // R4
    inval_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && cyc_kind == 2'b11) |-> (addr_out == addr_in));

    // R2
    mask_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eff_mask) |-> ($past(pre_stage) || $past(io_done)));

    // R3
    mask_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(eff_mask) |-> (!$past(pre_stage) || $past(io_done)));

    // R7
    cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(held));

    // R9
    ignore_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ignoring |=> !stage_first);

    // R9
    viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reset_viol) |-> reset_viol);
endmodule

bind a20_wrap_unit a20m_chk #(
    .ADDR_W  (ADDR_W),
    .MASK_BIT(MASK_BIT)
) u_a20m_chk (
    .clk        (clk),
    .rst        (rst),
    .real_mode  (real_mode),
    .cyc_kind   (cyc_kind),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .eff_mask   (eff_mask),
    .pre_stage  (pre_stage),
    .stage_first(stage_first),
    .ignoring   (ignoring),
    .io_done    (io_done),
    .busy       (busy),
    .held       (held),
    .reset_viol (reset_viol)
);

// File: tb/test_a20_wrap_unit.sv
module test_a20_wrap_unit;
    localparam logic [31:0] BIT20 = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mask_req_n = 1'b1;
    logic        real_mode = 1'b1;
    logic [1:0]  cyc_kind = 2'b00;
    logic        strobe = 1'b0;
    logic        rdy = 1'b0;
    logic        last_xfer = 1'b0;
    logic [31:0] addr_in = 32'h0012_3456;
    logic [31:0] addr_out;
    logic        reset_viol;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    a20_wrap_unit i_a20_wrap_unit (
        .clk       (clk),
        .rst       (rst),
        .mask_req_n(mask_req_n),
        .real_mode (real_mode),
        .cyc_kind  (cyc_kind),
        .strobe    (strobe),
        .rdy       (rdy),
        .last_xfer (last_xfer),
        .addr_in   (addr_in),
        .addr_out  (addr_out),
        .reset_viol(reset_viol)
    );

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_addr(input string tag, input logic masked);
        logic [31:0] exp_v;
        #1;
        exp_v = masked ? (addr_in & ~BIT20) : addr_in;
        n_checks++;
        if (addr_out !== exp_v) begin
            n_fails++;
            $display("FAIL %s: addr_out=%h expected %h", tag, addr_out, exp_v);
        end
    endtask

    task automatic chk_viol(input string tag, input logic exp_v);
        #1;
        n_checks++;
        if (reset_viol !== exp_v) begin
            n_fails++;
            $display("FAIL %s: reset_viol=%b expected %b", tag, reset_viol, exp_v);
        end
    endtask

    task automatic do_reset(input logic req_n);
        rst = 1'b1; mask_req_n = req_n; strobe = 1'b0; rdy = 1'b0;
        last_xfer = 1'b0; cyc_kind = 2'b00; real_mode = 1'b1;
        addr_in = 32'h0012_3456;
        nclk(2);
        rst = 1'b0;
        nclk(1);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        nclk(1);
        chk_addr("R1 in reset", 1'b0);
        do_reset(1'b1);
        chk_addr("R1 after reset", 1'b0);
        chk_viol("R1 viol clear", 1'b0);
    endtask

    task automatic t_latency();
        do_reset(1'b1);
        mask_req_n = 1'b0;
        chk_addr("R2 at request", 1'b0);
        nclk(3);
        chk_addr("R2 edge 3 not yet", 1'b0);
        nclk(1);
        chk_addr("R2 edge 4 masked", 1'b1);
        addr_in = 32'hFFFF_FFFF;
        chk_addr("R10 all ones", 1'b1);
        addr_in = 32'hA5F0_0F5A;
        chk_addr("R10 pattern", 1'b1);
        addr_in = 32'h0012_3456;
        mask_req_n = 1'b1;
        nclk(3);
        chk_addr("R3 edge 3 still masked", 1'b1);
        nclk(1);
        chk_addr("R3 edge 4 released", 1'b0);
    endtask

    task automatic t_inval_prot();
        do_reset(1'b1);
        mask_req_n = 1'b0;
        nclk(4);
        chk_addr("R4 baseline masked", 1'b1);
        cyc_kind = 2'b11;
        chk_addr("R4 idle invalidation", 1'b0);
        strobe = 1'b1;
        nclk(1);
        strobe = 1'b0; cyc_kind = 2'b00;
        chk_addr("R4 latched invalidation", 1'b0);
        rdy = 1'b1;
        nclk(1);
        rdy = 1'b0;
        chk_addr("R4 after invalidation", 1'b1);
        real_mode = 1'b0;
        chk_addr("R5 protected mode", 1'b0);
        real_mode = 1'b1;
    endtask

    task automatic t_data_cycle();
        do_reset(1'b1);
        strobe = 1'b1; mask_req_n = 1'b0;
        chk_addr("R6 strobe unmasked", 1'b0);
        nclk(1);
        strobe = 1'b0;
        nclk(5);
        chk_addr("R6 held unmasked", 1'b0);
        rdy = 1'b1;
        chk_addr("R6 at rdy", 1'b0);
        nclk(1);
        rdy = 1'b0;
        chk_addr("R6 next uses mask", 1'b1);
        strobe = 1'b1;
        chk_addr("R6 masked strobe", 1'b1);
        nclk(1);
        strobe = 1'b0; mask_req_n = 1'b1;
        nclk(5);
        chk_addr("R6 held masked", 1'b1);
        rdy = 1'b1;
        nclk(1);
        rdy = 1'b0;
        chk_addr("R6 next released", 1'b0);
    endtask

    task automatic t_prefetch();
        do_reset(1'b1);
        cyc_kind = 2'b01; strobe = 1'b1; mask_req_n = 1'b0;
        nclk(1);
        strobe = 1'b0;
        nclk(1);
        rdy = 1'b1; last_xfer = 1'b0;
        nclk(1);
        rdy = 1'b0;
        nclk(1);
        strobe = 1'b1;
        nclk(1);
        strobe = 1'b0;
        nclk(1);
        chk_addr("R7 prefetch held", 1'b0);
        rdy = 1'b1; last_xfer = 1'b1;
        chk_addr("R7 last transfer", 1'b0);
        nclk(1);
        rdy = 1'b0; last_xfer = 1'b0; cyc_kind = 2'b00;
        chk_addr("R7 after prefetch", 1'b1);
    endtask

    task automatic t_io_write();
        do_reset(1'b1);
        cyc_kind = 2'b10; strobe = 1'b1; mask_req_n = 1'b0;
        nclk(1);
        strobe = 1'b0;
        nclk(1);
        rdy = 1'b1;
        chk_addr("R8 during io write", 1'b0);
        nclk(1);
        rdy = 1'b0; cyc_kind = 2'b00;
        chk_addr("R8 fast path", 1'b1);
    endtask

    task automatic t_reset_viol();
        do_reset(1'b0);
        chk_viol("R9 flag set", 1'b1);
        nclk(6);
        chk_addr("R9 request ignored", 1'b0);
        mask_req_n = 1'b1;
        nclk(1);
        mask_req_n = 1'b0;
        nclk(4);
        chk_addr("R9 works after release", 1'b1);
        chk_viol("R9 flag sticky", 1'b1);
        mask_req_n = 1'b1;
    endtask

    initial begin
        nclk(1);
        t_reset_state();
        t_latency();
        t_inval_prot();
        t_data_cycle();
        t_prefetch();
        t_io_write();
        t_reset_viol();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule